// File: doc/BRIEF.md
# Multi-Stream Byte-Packing DMA Engine

The engine carries byte data from a small set of input streams into memory, one transfer at a time. A controller hands it a command naming a stream, a byte address and an upper bound on the byte count. The engine pulls 64-bit words from that stream only and collects the bytes in an internal transfer buffer. It then issues one memory write command with the address and the byte count actually collected. The packed data follows as 64-bit words, and the engine finally returns a response with the stream, the size and a trigger indication.

Each input word carries up to eight valid bytes. A transfer that stops in the middle of a word does not lose the unused bytes: they stay in a per-stream remainder slot and open the next transfer on that stream. The byte sequence written to memory is therefore the stream's byte sequence without gaps, whatever the word boundaries are. A word that carries a trigger, timeout or end marker closes the transfer early, once all of its bytes have been placed.

Top module: `pack_dma`

## Requirements
- R1: A command is taken only while `cmd_rdy_o` is high. `cmd_rdy_o` falls in the cycle after acceptance and stays low until the response handshake of that command has completed.
- R2: Input word byte k sits in bits 8k+7:8k of the stream's 64-bit slice. Its valid count is 0..8 and counts from lane 0 upward. Only the commanded stream's `in_rdy_o` bit may be high, and at most one bit is high at any time.
- R3: When a transfer moves at least one byte, exactly one memory command is issued. Its address equals the command address and its size equals the bytes moved. Valid holds with stable fields until ready is seen and drops after the accepting edge.
- R4: A transfer of S bytes emits ceil(S/8) data words in order, with transfer byte j in lane j mod 8 of word j div 8. Lanes above S in the final word carry no meaning.
- R5: Across successive transfers on one stream, the first byte written is the stream byte that follows the last byte of the previous transfer, even when that byte sits mid-word.
- R6: Transfers on different streams may interleave, and each stream's byte continuity is unaffected by the other streams.
- R7: If a trigger-flagged word is fully placed within the size bound, the transfer ends after that word. The response size equals the bytes moved and `rsp_trig_o` is 1.
- R8: A word flagged timeout or end-of-data, with no trigger flag, ends the transfer in the same way, with `rsp_trig_o` 0.
- R9: If the size bound cuts a flagged word, its flag travels with the leftover bytes. The transfer that places those leftover bytes is the one that ends early.
- R10: A requested size above the buffer capacity (BUF_WORDS*8 bytes, 64 by default) is treated as that capacity.
- R11: A command with size 0 issues no memory command and no data, and returns a response of size 0.
- R12: The response holds its valid and fields stable until `rsp_rdy_i` is seen, and valid drops in the cycle after the handshake.
- R13: During and right after reset, `cmd_rdy_o` is 1, and all valid outputs and `in_rdy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Command valid |
| cmd_rdy_o | output | 1 | Engine idle, command accepted |
| cmd_stream_i | input | SEL_W | Stream index |
| cmd_addr_i | input | ADDR_W | Byte address |
| cmd_size_i | input | SIZE_W | Maximum byte count |
| in_vld_i | input | N_STREAMS | Per-stream word valid |
| in_rdy_o | output | N_STREAMS | Per-stream word ready |
| in_data_i | input | N_STREAMS*64 | Per-stream word, stream s in bits 64s+63:64s |
| in_bytes_i | input | N_STREAMS*4 | Per-stream valid byte count |
| in_last_i | input | N_STREAMS | End-of-data marker |
| in_tmo_i | input | N_STREAMS | Timeout marker |
| in_trig_i | input | N_STREAMS | Trigger marker |
| mem_cmd_vld_o | output | 1 | Memory command valid |
| mem_cmd_rdy_i | input | 1 | Memory command ready |
| mem_cmd_addr_o | output | ADDR_W | Write address |
| mem_cmd_size_o | output | SIZE_W | Bytes to write |
| mem_dat_vld_o | output | 1 | Write data valid |
| mem_dat_rdy_i | input | 1 | Write data ready |
| mem_dat_o | output | 64 | Packed write data |
| rsp_vld_o | output | 1 | Response valid |
| rsp_rdy_i | input | 1 | Response ready |
| rsp_stream_o | output | SEL_W | Stream of the finished transfer |
| rsp_size_o | output | SIZE_W | Bytes written |
| rsp_trig_o | output | 1 | Ended by a trigger word |

## Verification
The assertions assume that the memory and response sides eventually raise their ready signals. They also assume that every input word reports at most eight valid bytes and that the command stream index names an existing stream. The bench drives only byte counts from 1 to 8 and stream indices 0 and 1. Its memory and response ready patterns, whether toggling or held high, always return to 1 within a few cycles. Input valid gaps on one stream are allowed, since the engine places no rule on them.

// File: rtl/pack_dma_pkg.sv
package pack_dma_pkg;
  localparam int LANES  = 8;
  localparam int WORD_W = LANES * 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REM, ST_GATHER, ST_MCMD, ST_MDAT, ST_RSP
  } dma_state_e;

  // leftover bytes of a partly used input word, low lanes first
  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [CNT_W-1:0]  cnt;
    logic              fin;
    logic              trig;
  } rem_t;
endpackage

// File: rtl/pack_dma_rem_bank.sv
module pack_dma_rem_bank
  import pack_dma_pkg::*;
#(
  parameter int N_STREAMS = 2,
  parameter int SEL_W     = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] rd_sel_i,
  output rem_t             rd_o,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  rem_t             wr_i
);
  rem_t slots [N_STREAMS];

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_slot
    rem_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= '0;
      else if (wr_en_i && (int'(wr_sel_i) == g)) slot_q <= wr_i;
    end
    assign slots[g] = slot_q;
  end

  assign rd_o = slots[rd_sel_i];
endmodule

// File: rtl/pack_dma_in_sel.sv
module pack_dma_in_sel
  import pack_dma_pkg::*;
#(
  parameter int N_STREAMS = 2,
  parameter int SEL_W     = 1
) (
  input  logic [SEL_W-1:0]            sel_i,
  input  logic                        take_i,
  input  logic [N_STREAMS-1:0]        in_vld_i,
  input  logic [N_STREAMS*WORD_W-1:0] in_data_i,
  input  logic [N_STREAMS*CNT_W-1:0]  in_bytes_i,
  input  logic [N_STREAMS-1:0]        in_last_i,
  input  logic [N_STREAMS-1:0]        in_tmo_i,
  input  logic [N_STREAMS-1:0]        in_trig_i,
  output logic [N_STREAMS-1:0]        in_rdy_o,
  output logic                        vld_o,
  output logic [WORD_W-1:0]           data_o,
  output logic [CNT_W-1:0]            cnt_o,
  output logic                        fin_o,
  output logic                        trig_o
);
  logic [CNT_W-1:0] raw_cnt;

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_rdy
    assign in_rdy_o[g] = take_i && (int'(sel_i) == g);
  end

  assign vld_o   = take_i && in_vld_i[sel_i];
  assign data_o  = in_data_i[int'(sel_i)*WORD_W +: WORD_W];
  assign raw_cnt = in_bytes_i[int'(sel_i)*CNT_W +: CNT_W];
  assign cnt_o   = (raw_cnt > CNT_W'(LANES)) ? CNT_W'(LANES) : raw_cnt;
  assign fin_o   = in_last_i[sel_i] | in_tmo_i[sel_i] | in_trig_i[sel_i];
  assign trig_o  = in_trig_i[sel_i];
endmodule

// File: rtl/pack_dma_byte_buf.sv
module pack_dma_byte_buf
  import pack_dma_pkg::*;
#(
  parameter int BUF_WORDS = 8,
  parameter int FILL_W    = 7,
  parameter int WIDX_W    = 3
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [FILL_W-1:0] wr_pos_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [WIDX_W-1:0] rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int BUF_BYTES = BUF_WORDS * LANES;

  logic [7:0] bytes [BUF_BYTES];

  // each byte cell picks its lane from the incoming word by its distance to the fill point
  for (genvar j = 0; j < BUF_BYTES; j++) begin : g_cell
    localparam logic [FILL_W:0] POS = (FILL_W+1)'(j);
    logic [FILL_W:0] off;
    logic            hit;
    logic [7:0]      byte_q;
    assign off = POS - {1'b0, wr_pos_i};
    assign hit = wr_en_i && (POS >= {1'b0, wr_pos_i}) &&
                 (off < {{(FILL_W-3){1'b0}}, wr_cnt_i});
    always_ff @(posedge clk_i) begin
      if (hit) byte_q <= wr_data_i[{off[2:0], 3'b000} +: 8];
    end
    assign bytes[j] = byte_q;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rd_data_o[k*8 +: 8] = bytes[{rd_idx_i, 3'(k)}];
  end
endmodule

// File: rtl/pack_dma.sv
module pack_dma
  import pack_dma_pkg::*;
#(
  parameter int N_STREAMS = 2,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int BUF_WORDS = 8,
  localparam int SEL_W    = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_vld_i,
  output logic                        cmd_rdy_o,
  input  logic [SEL_W-1:0]            cmd_stream_i,
  input  logic [ADDR_W-1:0]           cmd_addr_i,
  input  logic [SIZE_W-1:0]           cmd_size_i,
  input  logic [N_STREAMS-1:0]        in_vld_i,
  output logic [N_STREAMS-1:0]        in_rdy_o,
  input  logic [N_STREAMS*64-1:0]     in_data_i,
  input  logic [N_STREAMS*4-1:0]      in_bytes_i,
  input  logic [N_STREAMS-1:0]        in_last_i,
  input  logic [N_STREAMS-1:0]        in_tmo_i,
  input  logic [N_STREAMS-1:0]        in_trig_i,
  output logic                        mem_cmd_vld_o,
  input  logic                        mem_cmd_rdy_i,
  output logic [ADDR_W-1:0]           mem_cmd_addr_o,
  output logic [SIZE_W-1:0]           mem_cmd_size_o,
  output logic                        mem_dat_vld_o,
  input  logic                        mem_dat_rdy_i,
  output logic [63:0]                 mem_dat_o,
  output logic                        rsp_vld_o,
  input  logic                        rsp_rdy_i,
  output logic [SEL_W-1:0]            rsp_stream_o,
  output logic [SIZE_W-1:0]           rsp_size_o,
  output logic                        rsp_trig_o
);
  localparam int BUF_BYTES = BUF_WORDS * LANES;
  localparam int FILL_W    = $clog2(BUF_BYTES + 1);
  localparam int WIDX_W    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  dma_state_e        state_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [FILL_W-1:0] max_q, fill_q;
  logic [WIDX_W-1:0] widx_q;
  logic              trig_q;

  // stream input selection
  logic              w_vld, w_fin, w_trig;
  logic [WORD_W-1:0] w_data;
  logic [CNT_W-1:0]  w_cnt;

  pack_dma_in_sel #(.N_STREAMS(N_STREAMS), .SEL_W(SEL_W)) u_in_sel (
    .sel_i      (sel_q),
    .take_i     (state_q == ST_GATHER),
    .in_vld_i   (in_vld_i),
    .in_data_i  (in_data_i),
    .in_bytes_i (in_bytes_i),
    .in_last_i  (in_last_i),
    .in_tmo_i   (in_tmo_i),
    .in_trig_i  (in_trig_i),
    .in_rdy_o   (in_rdy_o),
    .vld_o      (w_vld),
    .data_o     (w_data),
    .cnt_o      (w_cnt),
    .fin_o      (w_fin),
    .trig_o     (w_trig)
  );

  // per-stream leftover storage
  rem_t rem_rd, rem_wr, src;
  logic step;

  pack_dma_rem_bank #(.N_STREAMS(N_STREAMS), .SEL_W(SEL_W)) u_rem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_sel_i (sel_q),
    .rd_o     (rem_rd),
    .wr_en_i  (step),
    .wr_sel_i (sel_q),
    .wr_i     (rem_wr)
  );

  // source of bytes this cycle: leftover first, then live words
  always_comb begin
    if (state_q == ST_REM) begin
      src = rem_rd;
    end else begin
      src.data = w_data;
      src.cnt  = w_cnt;
      src.fin  = w_fin;
      src.trig = w_trig;
    end
  end

  logic [FILL_W-1:0] room, src_cnt_w, take_w, fill_nx;
  logic [CNT_W-1:0]  left_cnt;
  logic              end_now, done;

  assign step      = (state_q == ST_REM) || ((state_q == ST_GATHER) && w_vld);
  assign room      = max_q - fill_q;
  assign src_cnt_w = FILL_W'(src.cnt);
  assign take_w    = (src_cnt_w > room) ? room : src_cnt_w;
  assign left_cnt  = src.cnt - take_w[CNT_W-1:0];
  assign end_now   = (left_cnt == '0) && src.fin;
  assign fill_nx   = fill_q + take_w;
  assign done      = end_now || (fill_nx == max_q);

  always_comb begin
    rem_wr.data = src.data >> {take_w[CNT_W-1:0], 3'b000};
    rem_wr.cnt  = left_cnt;
    rem_wr.fin  = src.fin && (left_cnt != '0);
    rem_wr.trig = src.trig && (left_cnt != '0);
  end

  // transfer buffer
  logic [WORD_W-1:0] rd_word;

  pack_dma_byte_buf #(.BUF_WORDS(BUF_WORDS), .FILL_W(FILL_W), .WIDX_W(WIDX_W)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (step),
    .wr_pos_i  (fill_q),
    .wr_cnt_i  (take_w[CNT_W-1:0]),
    .wr_data_i (src.data),
    .rd_idx_i  (widx_q),
    .rd_data_o (rd_word)
  );

  // command capture with size cap
  logic [FILL_W-1:0] max_in;
  assign max_in = (cmd_size_i > SIZE_W'(BUF_BYTES)) ? FILL_W'(BUF_BYTES)
                                                    : cmd_size_i[FILL_W-1:0];

  logic [FILL_W-1:0] fill_m1;
  logic [WIDX_W-1:0] last_widx;
  assign fill_m1   = fill_q - 1'b1;
  assign last_widx = fill_m1[WIDX_W+2:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      addr_q  <= '0;
      max_q   <= '0;
      fill_q  <= '0;
      widx_q  <= '0;
      trig_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_vld_i) begin
          sel_q   <= cmd_stream_i;
          addr_q  <= cmd_addr_i;
          max_q   <= max_in;
          fill_q  <= '0;
          trig_q  <= 1'b0;
          state_q <= ST_REM;
        end
        ST_REM, ST_GATHER: if (step) begin
          fill_q <= fill_nx;
          widx_q <= '0;
          if (done) begin
            trig_q  <= end_now && src.trig;
            state_q <= (fill_nx == '0) ? ST_RSP : ST_MCMD;
          end else begin
            state_q <= ST_GATHER;
          end
        end
        ST_MCMD: if (mem_cmd_rdy_i) state_q <= ST_MDAT;
        ST_MDAT: if (mem_dat_rdy_i) begin
          if (widx_q == last_widx) state_q <= ST_RSP;
          else widx_q <= widx_q + 1'b1;
        end
        ST_RSP: if (rsp_rdy_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_rdy_o      = (state_q == ST_IDLE);
  assign mem_cmd_vld_o  = (state_q == ST_MCMD);
  assign mem_cmd_addr_o = addr_q;
  assign mem_cmd_size_o = SIZE_W'(fill_q);
  assign mem_dat_vld_o  = (state_q == ST_MDAT);
  assign mem_dat_o      = rd_word;
  assign rsp_vld_o      = (state_q == ST_RSP);
  assign rsp_stream_o   = sel_q;
  assign rsp_size_o     = SIZE_W'(fill_q);
  assign rsp_trig_o     = trig_q;
endmodule

// File: rtl/pack_dma_chk.sv
module pack_dma_chk #(
  parameter int N_STREAMS = 2,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int SEL_W     = 1,
  parameter int BUF_BYTES = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_vld_i,
  input logic                 cmd_rdy_o,
  input logic [N_STREAMS-1:0] in_rdy_o,
  input logic                 mem_cmd_vld_o,
  input logic                 mem_cmd_rdy_i,
  input logic [ADDR_W-1:0]    mem_cmd_addr_o,
  input logic [SIZE_W-1:0]    mem_cmd_size_o,
  input logic                 mem_dat_vld_o,
  input logic                 rsp_vld_o,
  input logic                 rsp_rdy_i,
  input logic [SEL_W-1:0]     rsp_stream_o,
  input logic [SIZE_W-1:0]    rsp_size_o,
  input logic                 rsp_trig_o
);
  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i && cmd_rdy_o |=> !cmd_rdy_o);

  a_r1_idle_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rdy_o |-> !mem_cmd_vld_o && !mem_dat_vld_o && !rsp_vld_o && (in_rdy_o == '0));

  a_r2_one_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_rdy_o));

  a_r3_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cmd_vld_o && !mem_cmd_rdy_i |=>
      mem_cmd_vld_o && $stable(mem_cmd_addr_o) && $stable(mem_cmd_size_o));

  a_r3_cmd_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cmd_vld_o && mem_cmd_rdy_i |=> !mem_cmd_vld_o);

  a_r10_cmd_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cmd_vld_o |-> (mem_cmd_size_o != '0) && (mem_cmd_size_o <= SIZE_W'(BUF_BYTES)));

  a_r12_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o && !rsp_rdy_i |=>
      rsp_vld_o && $stable(rsp_size_o) && $stable(rsp_stream_o) && $stable(rsp_trig_o));

  a_r12_rsp_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o && rsp_rdy_i |=> !rsp_vld_o);

  a_r11_trig_needs_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o && rsp_trig_o |-> rsp_size_o != '0);
endmodule

bind pack_dma pack_dma_chk #(
  .N_STREAMS (N_STREAMS),
  .ADDR_W    (ADDR_W),
  .SIZE_W    (SIZE_W),
  .SEL_W     (SEL_W),
  .BUF_BYTES (BUF_WORDS * 8)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_vld_i      (cmd_vld_i),
  .cmd_rdy_o      (cmd_rdy_o),
  .in_rdy_o       (in_rdy_o),
  .mem_cmd_vld_o  (mem_cmd_vld_o),
  .mem_cmd_rdy_i  (mem_cmd_rdy_i),
  .mem_cmd_addr_o (mem_cmd_addr_o),
  .mem_cmd_size_o (mem_cmd_size_o),
  .mem_dat_vld_o  (mem_dat_vld_o),
  .rsp_vld_o      (rsp_vld_o),
  .rsp_rdy_i      (rsp_rdy_i),
  .rsp_stream_o   (rsp_stream_o),
  .rsp_size_o     (rsp_size_o),
  .rsp_trig_o     (rsp_trig_o)
);

// File: tb/pack_dma_bench.sv
`timescale 1ns/1ps
module pack_dma_bench;
  localparam int NS = 2;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int BB = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic              cmd_vld = 1'b0;
  logic              cmd_rdy_o;
  logic [0:0]        cmd_stream = '0;
  logic [AW-1:0]     cmd_addr = '0;
  logic [SW-1:0]     cmd_size = '0;
  logic [NS-1:0]     in_vld = '0;
  logic [NS-1:0]     in_rdy_o;
  logic [NS*64-1:0]  in_data = '0;
  logic [NS*4-1:0]   in_bytes = '0;
  logic [NS-1:0]     in_last = '0, in_tmo = '0, in_trig = '0;
  logic              mem_cmd_vld_o, mem_cmd_rdy = 1'b0;
  logic [AW-1:0]     mem_cmd_addr_o;
  logic [SW-1:0]     mem_cmd_size_o;
  logic              mem_dat_vld_o, mem_dat_rdy = 1'b0;
  logic [63:0]       mem_dat_o;
  logic              rsp_vld_o, rsp_rdy = 1'b0;
  logic [0:0]        rsp_stream_o;
  logic [SW-1:0]     rsp_size_o;
  logic              rsp_trig_o;

  pack_dma u_pack_dma (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_vld_i(cmd_vld), .cmd_rdy_o(cmd_rdy_o), .cmd_stream_i(cmd_stream),
    .cmd_addr_i(cmd_addr), .cmd_size_i(cmd_size),
    .in_vld_i(in_vld), .in_rdy_o(in_rdy_o), .in_data_i(in_data), .in_bytes_i(in_bytes),
    .in_last_i(in_last), .in_tmo_i(in_tmo), .in_trig_i(in_trig),
    .mem_cmd_vld_o(mem_cmd_vld_o), .mem_cmd_rdy_i(mem_cmd_rdy),
    .mem_cmd_addr_o(mem_cmd_addr_o), .mem_cmd_size_o(mem_cmd_size_o),
    .mem_dat_vld_o(mem_dat_vld_o), .mem_dat_rdy_i(mem_dat_rdy), .mem_dat_o(mem_dat_o),
    .rsp_vld_o(rsp_vld_o), .rsp_rdy_i(rsp_rdy), .rsp_stream_o(rsp_stream_o),
    .rsp_size_o(rsp_size_o), .rsp_trig_o(rsp_trig_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stream word tables: counts 1..8 (R2), flag 0 none, 1 trigger, 2 timeout, 3 end
  function automatic int wcnt(int s, int i);
    if (s == 0) return (i == 3) ? 5 : (i == 9) ? 6 : 8;
    return 1 + (i % 8);
  endfunction

  function automatic int wflag(int s, int i);
    if (s == 0) return (i == 11) ? 1 : (i == 20) ? 2 : (i == 25) ? 3 : 0;
    return (i == 6) ? 1 : (i == 15) ? 2 : (i == 22) ? 1 : (i == 30) ? 3 : 0;
  endfunction

  function automatic int wstart(int s, int i);
    int acc = 0;
    for (int j = 0; j < i; j++) acc += wcnt(s, j);
    return acc;
  endfunction

  function automatic logic [7:0] bval(int s, int n);
    return 8'((n * 3 + s * 85 + 1) & 255);
  endfunction

  function automatic logic [63:0] wdata(int s, int i);
    logic [63:0] w;
    int st = wstart(s, i);
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = (k < wcnt(s, i)) ? bval(s, st + k) : 8'hEE;
    return w;
  endfunction

  // input feeders and ready patterns
  int widx [NS];
  bit acc  [NS];
  int cyc = 0;
  bit tog = 1'b0;
  int act_s = 0;
  int bad_rdy = 0;

  initial for (int s = 0; s < NS; s++) begin widx[s] = 0; acc[s] = 1'b0; end

  always @(negedge clk) begin
    cyc++;
    for (int s = 0; s < NS; s++) begin
      if (acc[s]) widx[s]++;
      in_data[s*64 +: 64] = wdata(s, widx[s]);
      in_bytes[s*4 +: 4]  = 4'(wcnt(s, widx[s]));
      in_trig[s] = (wflag(s, widx[s]) == 1);
      in_tmo[s]  = (wflag(s, widx[s]) == 2);
      in_last[s] = (wflag(s, widx[s]) == 3);
    end
    in_vld[0]   = 1'b1;
    in_vld[1]   = (cyc % 4) != 1;
    mem_cmd_rdy = tog ? ((cyc % 3) != 0) : 1'b1;
    mem_dat_rdy = tog ? ((cyc % 2) == 0) : 1'b1;
    rsp_rdy     = tog ? ((cyc % 5) == 2) : 1'b1;
  end

  // handshake logs
  int ncmd = 0, ndat = 0, nrsp = 0;
  logic [AW-1:0] cmd_addr_log [64];
  int            cmd_size_log [64];
  logic [63:0]   dat_log      [512];
  int            rsp_strm_log [64];
  int            rsp_size_log [64];
  bit            rsp_trig_log [64];

  always @(posedge clk) begin
    for (int s = 0; s < NS; s++) acc[s] <= in_vld[s] && in_rdy_o[s];
    if (rst_ni) begin
      for (int s = 0; s < NS; s++) if (in_rdy_o[s] && s != act_s) bad_rdy <= bad_rdy + 1;
      if (mem_cmd_vld_o && mem_cmd_rdy) begin
        cmd_addr_log[ncmd] <= mem_cmd_addr_o;
        cmd_size_log[ncmd] <= int'(mem_cmd_size_o);
        ncmd <= ncmd + 1;
      end
      if (mem_dat_vld_o && mem_dat_rdy) begin
        dat_log[ndat] <= mem_dat_o;
        ndat <= ndat + 1;
      end
      if (rsp_vld_o && rsp_rdy) begin
        rsp_strm_log[nrsp] <= int'(rsp_stream_o);
        rsp_size_log[nrsp] <= int'(rsp_size_o);
        rsp_trig_log[nrsp] <= rsp_trig_o;
        nrsp <= nrsp + 1;
      end
    end
  end

  // arithmetic model: consumed byte position per stream
  int pos [NS];

  task automatic predict(input int s, input int m, output int sz, output bit trg);
    int mm = (m > BB) ? BB : m;
    int cum = 0;
    int e = -1;
    int fl = 0;
    for (int i = 0; i < 200; i++) begin
      cum += wcnt(s, i);
      if (e < 0 && wflag(s, i) != 0 && cum > pos[s]) begin
        e = cum;
        fl = wflag(s, i);
      end
    end
    if (e < 0) e = pos[s] + 100000;
    sz  = (e - pos[s] < mm) ? (e - pos[s]) : mm;
    trg = (e - pos[s] <= mm) && (fl == 1);
  endtask

  task automatic xfer(input int s, input logic [AW-1:0] addr, input int m, input string tag);
    int c0, d0, r0, sz, nw, bad;
    bit trg;
    do @(negedge clk); while (!cmd_rdy_o);
    c0 = ncmd; d0 = ndat; r0 = nrsp; act_s = s;
    cmd_vld = 1'b1; cmd_stream = 1'(s); cmd_addr = addr; cmd_size = SW'(m);
    @(negedge clk);
    cmd_vld = 1'b0;
    chk(cmd_rdy_o == 1'b0, "R1 busy after accept", cmd_rdy_o, 0);
    while (nrsp == r0) @(negedge clk);
    chk(rsp_vld_o == 1'b0, "R12 response drop", rsp_vld_o, 0);
    predict(s, m, sz, trg);
    nw = (sz + 7) / 8;
    chk(ncmd - c0 == ((sz > 0) ? 1 : 0), {tag, " mem command count"}, ncmd - c0, (sz > 0) ? 1 : 0);
    if (sz > 0 && ncmd > c0) begin
      chk(cmd_addr_log[c0] == addr, "R3 mem address", cmd_addr_log[c0], addr);
      chk(cmd_size_log[c0] == sz, {tag, " mem size"}, cmd_size_log[c0], sz);
    end
    chk(ndat - d0 == nw, "R4 data word count", ndat - d0, nw);
    bad = 0;
    for (int j = 0; j < sz; j++)
      if (d0 + j / 8 < ndat && dat_log[d0 + j / 8][(j % 8) * 8 +: 8] != bval(s, pos[s] + j)) bad++;
    chk(bad == 0, {tag, " R5 byte content"}, bad, 0);
    chk(rsp_strm_log[r0] == s, "R12 response stream", rsp_strm_log[r0], s);
    chk(rsp_size_log[r0] == sz, {tag, " response size"}, rsp_size_log[r0], sz);
    chk(rsp_trig_log[r0] == trg, {tag, " response trigger"}, rsp_trig_log[r0], trg);
    chk(bad_rdy == 0, "R2 foreign ready", bad_rdy, 0);
    pos[s] += sz;
  endtask

  initial begin
    pos[0] = 0; pos[1] = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(cmd_rdy_o == 1'b1, "R13 cmd ready in reset", cmd_rdy_o, 1);
    chk({mem_cmd_vld_o, mem_dat_vld_o, rsp_vld_o} == 3'b000, "R13 valids in reset",
        {mem_cmd_vld_o, mem_dat_vld_o, rsp_vld_o}, 0);
    chk(in_rdy_o == '0, "R13 input ready in reset", in_rdy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cmd_rdy_o == 1'b1 && !rsp_vld_o, "R13 after reset", cmd_rdy_o, 1);

    xfer(0, 32'h0000_1000, 30, "R5");
    xfer(0, 32'h0000_2000, 34, "R5");
    xfer(0, 32'h0000_3000, 30, "R7");
    tog = 1'b1;
    xfer(1, 32'h0000_8000, 20, "R6");
    xfer(0, 32'h0000_4000, 100, "R10");
    xfer(1, 32'h0000_8100, 13, "R7");
    xfer(0, 32'h0000_5000, 5, "R9");
    xfer(1, 32'h0000_8200, 64, "R8");
    xfer(0, 32'h0000_6000, 10, "R9");
    xfer(0, 32'h0000_7000, 0, "R11");
    xfer(1, 32'h0000_8300, 17, "R6");
    xfer(0, 32'h0000_7100, 64, "R8");
    xfer(1, 32'h0000_8400, 64, "R7");
    tog = 1'b0;
    xfer(1, 32'h0000_8500, 64, "R8");
    xfer(0, 32'h0000_7200, 64, "R6");
    xfer(1, 32'h0000_8600, 7, "R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule